// File: doc/BRIEF.md
# CPU Interrupt Approval Controller

This block chooses the interrupt the processor services next and hands its vector number to the interrupt sequencer. It watches sixteen maskable request lines (fourteen general lines, a data-logging line and a real-time operating-system line), a nonmaskable pin, an illegal-instruction trap strobe, numbered software requests from the instruction decoder, and the processor reset. Maskable requests are held in a flag register and pass through an enable register, a global mask bit and, in real-time debug halt, a second enable register and a debug mask bit. Nonmaskable sources bypass all of that gating.

An approval is a one-cycle strobe together with a 5-bit vector. After an approval the block issues nothing more until the sequencer acknowledges. While the processor is halted in stop mode nothing is approved, not even a nonmaskable source. Pending sources stay pending and are served once the halt ends. A software request that names a maskable source is served regardless of every enable and mask bit. It never sets that source's flag, but its approval clears the flag.

Top module: `irq_approve_ctrl`

## Requirements
- R1: While `rst_n` is low, `approve_o` is 0. The first approval after reset is released is issued one clock edge later and carries vector 0 (reset), ahead of every other source.
- R2: A rising edge on `line_i[k]` sets `flags_o[k]` at that edge. If the line is eligible, it is approved at the following edge with vector k+1, and `flags_o[k]` returns to 0 at that same edge.
- R3: A flagged line whose enable bit is 0, or any flagged line while `gmask_i` is 1, is not approved and its flag stays set. It is approved once the gating clears.
- R4: When several eligible flags are pending, they are approved one per acknowledge in ascending line order (lowest index first).
- R5: While `rt_halt_i` is 1, a maskable line also needs its debug-enable bit set and `dbgmask_i` at 0.
- R6: A rising edge on `nmi_i` gives exactly one approval with vector 18, whatever the masks and enables hold. Holding the pin high gives no further approval.
- R7: A `sw_req_i` strobe is approved at the following edge with vector `sw_num_i`, ignoring all masks and enables. It never sets a flag. When `sw_num_i` is in 1..16, its approval clears `flags_o[sw_num_i-1]`.
- R8: An `ill_trap_i` strobe is approved with vector 19, ignoring all masks and enables.
- R9: Priority is reset, then illegal trap, then software request, then NMI, then maskable lines.
- R10: While `stop_i` is 1, no approval is issued. Pending sources are kept and are approved at the first edge after `stop_i` falls.
- R11: `approve_o` is high for exactly one cycle. No further approval is issued until `ack_i` has been sampled high.
- R12: The enable and debug-enable registers load `en_wdata_i` / `dbg_en_wdata_i` only at an edge where `en_wr_i` / `dbg_en_wr_i` is 1. At other edges the write data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset; also raises the reset source |
| line_i | input | 16 | Maskable request lines, edge-sensitive |
| nmi_i | input | 1 | Nonmaskable request pin, edge-sensitive |
| ill_trap_i | input | 1 | Illegal-instruction trap strobe |
| sw_req_i | input | 1 | Software interrupt request strobe from the decoder |
| sw_num_i | input | 5 | Vector number named by the software request |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 16 | Enable register write data |
| dbg_en_wr_i | input | 1 | Write strobe for the debug-enable register |
| dbg_en_wdata_i | input | 16 | Debug-enable register write data |
| gmask_i | input | 1 | Global mask for maskable lines (1 = masked) |
| dbgmask_i | input | 1 | Debug mask, used in real-time debug halt (1 = masked) |
| rt_halt_i | input | 1 | Real-time debug halt mode active |
| stop_i | input | 1 | Processor halted in stop mode |
| ack_i | input | 1 | Sequencer acknowledge of the last approval |
| approve_o | output | 1 | One-cycle approval strobe |
| vec_o | output | 5 | Vector number of the approval |
| flags_o | output | 16 | Current flag register |

## Verification
Each maskable line is tried alone with only its own enable set. This separates the vector mapping and the flag clearing per line. Mixed flag patterns raised under the global mask and then released show whether the lowest-index ordering holds across acknowledges. All 32 software numbers are issued with every enable cleared, which separates "ignores gating" from "sets a flag". A single cycle carrying every nonmaskable kind plus a maskable line, and bursts held off by stop mode or a missing acknowledge, tell the priority order apart from the hold-off rules.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_RESET,
      SRC_ILLEGAL,
      SRC_SOFT,
      SRC_NMI,
      SRC_MASKABLE
   } src_e;

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
   parameter int WIDTH       = 17,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_i,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] level;
   logic [WIDTH-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pins_i;
      end else begin : g_sync
         logic [WIDTH-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= pins_i;
               for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign level = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise_o = level & ~prev_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flags_o
);

   logic [WIDTH-1:0] flags_q;

   // a fresh edge wins over a clear in the same cycle so no request is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int WIDTH = 16,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = WIDTH - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/irq_approve_ctrl.sv
module irq_approve_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int VEC_W       = 5,
   parameter int SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic                 nmi_i,
   input  logic                 ill_trap_i,
   input  logic                 sw_req_i,
   input  logic [VEC_W-1:0]     sw_num_i,
   input  logic                 en_wr_i,
   input  logic [NUM_LINES-1:0] en_wdata_i,
   input  logic                 dbg_en_wr_i,
   input  logic [NUM_LINES-1:0] dbg_en_wdata_i,
   input  logic                 gmask_i,
   input  logic                 dbgmask_i,
   input  logic                 rt_halt_i,
   input  logic                 stop_i,
   input  logic                 ack_i,
   output logic                 approve_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic [NUM_LINES-1:0] flags_o
);

   localparam int IDX_W   = $clog2(NUM_LINES);
   localparam int PINS    = NUM_LINES + 1;
   localparam int VEC_RST = 0;
   localparam int VEC_NMI = NUM_LINES + 2;
   localparam int VEC_ILL = NUM_LINES + 3;

   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("NUM_LINES must be at least 2");
      end
      if (VEC_ILL >= (1 << VEC_W)) begin : g_bad_vec
         $error("VEC_W too narrow for the vector numbering");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   // ---------------- pin edge capture ----------------
   logic [PINS-1:0] rise;

   irq_pin_capture #(
      .WIDTH       (PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i ({nmi_i, line_i}),
      .rise_o (rise)
   );

   // ---------------- enable registers ----------------
   logic [NUM_LINES-1:0] en_q;
   logic [NUM_LINES-1:0] dbg_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         dbg_en_q <= '0;
      end else begin
         if (en_wr_i)     en_q     <= en_wdata_i;
         if (dbg_en_wr_i) dbg_en_q <= dbg_en_wdata_i;
      end
   end

   // ---------------- flag register ----------------
   logic [NUM_LINES-1:0] flag_clr;
   logic [NUM_LINES-1:0] flags;

   irq_flag_bank #(
      .WIDTH (NUM_LINES)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (rise[NUM_LINES-1:0]),
      .clr_i   (flag_clr),
      .flags_o (flags)
   );

   // ---------------- maskable eligibility ----------------
   logic [NUM_LINES-1:0] dbg_gate;
   logic [NUM_LINES-1:0] eligible;
   logic                 mask_found;
   logic [IDX_W-1:0]     mask_idx;

   assign dbg_gate = rt_halt_i ? (dbg_en_q & {NUM_LINES{~dbgmask_i}})
                               : {NUM_LINES{1'b1}};
   assign eligible = flags & en_q & dbg_gate & {NUM_LINES{~gmask_i}};

   irq_lowest_pick #(
      .WIDTH (NUM_LINES)
   ) u_pick (
      .req_i   (eligible),
      .found_o (mask_found),
      .idx_o   (mask_idx)
   );

   // ---------------- nonmaskable pending state ----------------
   logic             rst_pend_q;
   logic             ill_pend_q;
   logic             nmi_pend_q;
   logic             sw_pend_q;
   logic [VEC_W-1:0] sw_num_q;
   logic             busy_q;
   logic             take;
   src_e             src;
   logic [VEC_W-1:0] vec_next;

   always_comb begin
      if (rst_pend_q)      src = SRC_RESET;
      else if (ill_pend_q) src = SRC_ILLEGAL;
      else if (sw_pend_q)  src = SRC_SOFT;
      else if (nmi_pend_q) src = SRC_NMI;
      else if (mask_found) src = SRC_MASKABLE;
      else                 src = SRC_NONE;
   end

   assign take = !busy_q && !stop_i && (src != SRC_NONE);

   always_comb begin
      unique case (src)
         SRC_RESET:    vec_next = VEC_W'(VEC_RST);
         SRC_ILLEGAL:  vec_next = VEC_W'(VEC_ILL);
         SRC_SOFT:     vec_next = sw_num_q;
         SRC_NMI:      vec_next = VEC_W'(VEC_NMI);
         SRC_MASKABLE: vec_next = VEC_W'(mask_idx) + VEC_W'(1);
         default:      vec_next = '0;
      endcase
   end

   generate
      for (genvar k = 0; k < NUM_LINES; k++) begin : g_clr
         assign flag_clr[k] = take &&
            ((src == SRC_MASKABLE && mask_idx == IDX_W'(k)) ||
             (src == SRC_SOFT     && sw_num_q == VEC_W'(k + 1)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend_q <= 1'b1;
         ill_pend_q <= 1'b0;
         nmi_pend_q <= 1'b0;
         sw_pend_q  <= 1'b0;
         sw_num_q   <= '0;
      end else begin
         if (take && src == SRC_RESET) rst_pend_q <= 1'b0;

         if (ill_trap_i)                      ill_pend_q <= 1'b1;
         else if (take && src == SRC_ILLEGAL) ill_pend_q <= 1'b0;

         if (rise[NUM_LINES])             nmi_pend_q <= 1'b1;
         else if (take && src == SRC_NMI) nmi_pend_q <= 1'b0;

         if (sw_req_i && (!sw_pend_q || (take && src == SRC_SOFT))) begin
            sw_pend_q <= 1'b1;
            sw_num_q  <= sw_num_i;
         end else if (take && src == SRC_SOFT) begin
            sw_pend_q <= 1'b0;
         end
      end
   end

   // ---------------- approval handshake ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         approve_o <= 1'b0;
         vec_o     <= '0;
      end else begin
         approve_o <= take;
         if (take) begin
            vec_o  <= vec_next;
            busy_q <= 1'b1;
         end else if (ack_i) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign flags_o = flags;

endmodule

// File: rtl/irq_approve_chk.sv
module irq_approve_chk #(
   parameter int NUM_LINES   = 16,
   parameter int VEC_W       = 5,
   parameter int SYNC_STAGES = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] line_i,
   input logic                 stop_i,
   input logic                 ack_i,
   input logic                 approve_o,
   input logic [VEC_W-1:0]     vec_o,
   input logic [NUM_LINES-1:0] flags_o
);

   logic outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         outst_q <= 1'b0;
      else if (ack_i)     outst_q <= 1'b0;
      else if (approve_o) outst_q <= 1'b1;
   end

   // R11: one cycle wide
   a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      approve_o |=> !approve_o);

   // R11: nothing new while the previous approval is unacknowledged
   a_r11_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
      approve_o |-> !outst_q);

   // R10: stop mode blocks all approvals
   a_r10_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !approve_o);

   // R1: reset vector comes first
   a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n, 2) && $past(rst_n) && !$past(stop_i)) |-> (approve_o && vec_o == '0));

   generate
      if (SYNC_STAGES == 0) begin : g_flag_src
         for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
            // R2 / R7: a flag only rises after its own line was high
            a_r7_flag_from_line: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(flags_o[k]) |-> $past(line_i[k]));
         end
      end
   endgenerate

endmodule

bind irq_approve_ctrl irq_approve_chk #(
   .NUM_LINES   (NUM_LINES),
   .VEC_W       (VEC_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_i    (line_i),
   .stop_i    (stop_i),
   .ack_i     (ack_i),
   .approve_o (approve_o),
   .vec_o     (vec_o),
   .flags_o   (flags_o)
);

// File: tb/irq_approve_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_approve_ctrl_tb_top;

   localparam int NL = 16;
   localparam int VW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] line = '0;
   logic          nmi = 1'b0, ill = 1'b0, swr = 1'b0;
   logic [VW-1:0] swn = '0;
   logic          en_wr = 1'b0, dbg_wr = 1'b0;
   logic [NL-1:0] en_wd = '0, dbg_wd = '0;
   logic          gmask = 1'b0, dbgmask = 1'b0, rt = 1'b0, stop = 1'b0, ack = 1'b0;
   logic          approve;
   logic [VW-1:0] vec;
   logic [NL-1:0] flags;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   irq_approve_ctrl #(.NUM_LINES(NL), .VEC_W(VW), .SYNC_STAGES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_i(line), .nmi_i(nmi), .ill_trap_i(ill),
      .sw_req_i(swr), .sw_num_i(swn), .en_wr_i(en_wr), .en_wdata_i(en_wd),
      .dbg_en_wr_i(dbg_wr), .dbg_en_wdata_i(dbg_wd), .gmask_i(gmask),
      .dbgmask_i(dbgmask), .rt_halt_i(rt), .stop_i(stop), .ack_i(ack),
      .approve_o(approve), .vec_o(vec), .flags_o(flags)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic exp_appr(input int v, input string tag);
      int act;
      act = approve ? int'(vec) : -1;
      chk(approve === 1'b1 && int'(vec) == v, tag, act, v);
   endtask

   task automatic exp_none(input string tag);
      chk(approve === 1'b0, tag, int'(approve), 0);
   endtask

   task automatic exp_flags(input logic [NL-1:0] f, input string tag);
      chk(flags === f, tag, int'(flags), int'(f));
   endtask

   task automatic do_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   task automatic write_en(input logic [NL-1:0] d);
      en_wd = d; en_wr = 1'b1;
      step();
      en_wr = 1'b0;
   endtask

   task automatic pulse_line(input int k);
      line[k] = 1'b1;
      step();
      line = '0;
      step();
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [NL-1:0] pats [3];
      pats[0] = 16'hA5C3; pats[1] = 16'h8001; pats[2] = 16'h0F0F;

      // R1 / R9: reset state, reset vector before an NMI captured at release
      nmi = 1'b1;
      step(); step(); step();
      exp_none("R1 held in reset");
      exp_flags('0, "R1 flags after reset");
      rst_n = 1'b1;
      step();
      exp_appr(0, "R1 reset vector first");
      do_ack();
      nmi = 1'b0;
      step();
      exp_appr(18, "R9 NMI after reset");
      do_ack();

      // R2 / R12: each line alone with only its own enable
      for (int k = 0; k < NL; k++) begin
         write_en(NL'(1) << k);
         line[k] = 1'b1;
         step();
         line = '0;
         exp_flags(NL'(1) << k, "R2 flag set on edge");
         step();
         exp_appr(k + 1, "R2 line vector");
         exp_flags('0, "R2 flag cleared on approval");
         do_ack();
      end

      // R3 / R12: disabled line stays pending, write strobe required
      write_en('0);
      pulse_line(5);
      exp_none("R3 disabled not approved");
      exp_flags(NL'(1) << 5, "R3 flag kept");
      en_wd = '1;
      step(); step();
      exp_none("R12 data without strobe ignored");
      en_wr = 1'b1;
      step();
      en_wr = 1'b0;
      step();
      exp_appr(6, "R12 approved after enable write");
      do_ack();
      gmask = 1'b1;
      pulse_line(7);
      step();
      exp_none("R3 global mask blocks");
      gmask = 1'b0;
      step();
      exp_appr(8, "R3 approved after mask cleared");
      do_ack();

      // R4: ascending service order across patterns
      foreach (pats[p]) begin
         gmask = 1'b1;
         line = pats[p];
         step();
         line = '0;
         step();
         exp_flags(pats[p], "R4 pattern latched");
         gmask = 1'b0;
         for (int k = 0; k < NL; k++) begin
            if (pats[p][k]) begin
               step();
               exp_appr(k + 1, "R4 lowest first");
               do_ack();
            end
         end
         exp_flags('0, "R4 all served");
      end

      // R5: real-time debug halt gating
      rt = 1'b1;
      pulse_line(2);
      exp_none("R5 debug enable clear blocks");
      dbg_wd = '1; dbg_wr = 1'b1;
      step();
      dbg_wr = 1'b0;
      step();
      exp_appr(3, "R5 approved with debug enable");
      do_ack();
      dbgmask = 1'b1;
      pulse_line(9);
      exp_none("R5 debug mask blocks");
      dbgmask = 1'b0;
      step();
      exp_appr(10, "R5 approved after debug mask cleared");
      do_ack();
      rt = 1'b0;

      // R6: NMI ignores masks, one approval per edge
      gmask = 1'b1; write_en('0);
      nmi = 1'b1;
      step(); step();
      exp_appr(18, "R6 NMI vector");
      do_ack();
      step(); step();
      exp_none("R6 held pin no repeat");
      nmi = 1'b0;

      // R7: every software number, all gating closed
      for (int n = 0; n < 32; n++) begin
         swr = 1'b1; swn = VW'(n);
         step();
         swr = 1'b0;
         step();
         exp_appr(n, "R7 software vector");
         exp_flags('0, "R7 no flag set");
         do_ack();
      end
      pulse_line(11);
      exp_flags(NL'(1) << 11, "R7 flag pending before soft request");
      swr = 1'b1; swn = VW'(12);
      step();
      swr = 1'b0;
      step();
      exp_appr(12, "R7 soft request of pending line");
      exp_flags('0, "R7 soft request clears flag");
      do_ack();

      // R8: illegal trap
      ill = 1'b1;
      step();
      ill = 1'b0;
      step();
      exp_appr(19, "R8 illegal trap vector");
      do_ack();

      // R9: all kinds in one cycle
      gmask = 1'b0; write_en('1);
      ill = 1'b1; swr = 1'b1; swn = VW'(7); nmi = 1'b1; line[3] = 1'b1;
      step();
      ill = 1'b0; swr = 1'b0; nmi = 1'b0; line = '0;
      step();
      exp_appr(19, "R9 illegal first");
      do_ack(); step();
      exp_appr(7, "R9 software second");
      do_ack(); step();
      exp_appr(18, "R9 NMI third");
      do_ack(); step();
      exp_appr(4, "R9 maskable last");
      do_ack();

      // R10: stop mode holds off even NMI
      stop = 1'b1;
      nmi = 1'b1;
      step();
      nmi = 1'b0;
      step(); step(); step();
      exp_none("R10 stop blocks NMI");
      stop = 1'b0;
      step();
      exp_appr(18, "R10 served after stop");
      do_ack();

      // R11: one-cycle strobe, hold-off until acknowledge
      ill = 1'b1; nmi = 1'b1;
      step();
      ill = 1'b0; nmi = 1'b0;
      step();
      exp_appr(19, "R11 first approval");
      step();
      exp_none("R11 strobe one cycle");
      step(); step();
      exp_none("R11 waits for ack");
      do_ack(); step();
      exp_appr(18, "R11 next after ack");
      do_ack();
      step();
      exp_none("R11 idle at end");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule